// File: doc/BRIEF.md
# Global-History XOR-Indexed Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a register holding the outcomes of the most recently resolved branches. To find a counter it takes a slice of the branch address, starting just above the low-order bits that are always zero for aligned instructions, and XORs that slice with the history register.

A fetch stage presents an address with a valid strobe. In the same cycle, through combinational logic only, the block answers taken or not-taken, using the table and history as they stand. Some cycles later the execute stage reports the branch on a separate resolve port with its own address and actual outcome. On that clock edge the block moves the selected counter one step toward the outcome and shifts the outcome into the history.

The index width, the address width and the number of skipped low address bits are parameters. The table holds two to the power of the index width counters.

Top module: `ghist_xor_predictor`

## Requirements
- R1: While reset is high at a clock edge, the history is cleared to zero and every counter is set to 1 (weakly not-taken). After reset, every fetch predicts not-taken until some training has happened.
- R2: In the same cycle as a valid fetch, pred_taken equals bit 1 of the counter at index fetch_pc[PC_LSB +: HIST_BITS] XOR history, where 1 means taken.
- R3: pred_taken is 0 in any cycle where fetch_vld is 0.
- R4: When resolve_vld is 0, no counter and no history bit changes, whatever resolve_pc and resolve_taken hold.
- R5: When resolve_vld is 1, the counter at index resolve_pc[PC_LSB +: HIST_BITS] XOR current history goes up by one if resolve_taken is 1 and down by one if it is 0. No other counter changes.
- R6: Counters saturate. Training taken at 3 leaves 3, and training not-taken at 0 leaves 0.
- R7: On a valid resolve, the history shifts left by one, resolve_taken enters bit 0 and the oldest bit is dropped.
- R8: If a fetch and a resolve select the same counter in the same cycle, the prediction uses the counter value from before that cycle's update.
- R9: Address bits below PC_LSB and above PC_LSB+HIST_BITS-1 have no effect on either the prediction index or the training index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A branch address is presented for prediction |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| resolve_vld | input | 1 | A resolved branch is reported this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |
| pred_taken | output | 1 | Predicted direction for fetch_pc (1 = taken) |

## Verification
A wrong counter only shows at the port when a later fetch lands on that entry under a matching history. The bench therefore keeps its own copy of the table and history, and compares every fetch against that copy. A corrupted history bit moves every later index, so the next few predictions are likely to disagree with the copy. A counter that wraps instead of saturating shows up one training step after the limit, as an abrupt flip of the predicted direction. Stretches of training on a fixed history are used to expose both limits. The bench also puts fetch and resolve on the same entry in the same cycle, and it toggles address bits outside the index slice.

// File: rtl/gxp_pkg.sv
`timescale 1ns/1ps
package gxp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN   = 2'd0;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_RESET = 2'd1;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    function automatic ctr_t ctr_step(ctr_t c, dir_e outcome);
        ctr_t n;
        if (outcome == DIR_TAKEN) begin
            n = (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
        end else begin
            n = (c == CTR_MIN) ? c : ctr_t'(c - 2'd1);
        end
        return n;
    endfunction

    function automatic dir_e ctr_dir(ctr_t c);
        return dir_e'(c[1]);
    endfunction

endpackage

// File: rtl/gxp_history.sv
`timescale 1ns/1ps
module gxp_history #(
    parameter int HIST_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 shift_in,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_BITS-2:0], shift_in};
        end
    end

    assign hist = hist_q;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist == {$past(hist[HIST_BITS-2:0]), $past(shift_in)}); // R7

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist)); // R4

endmodule

// File: rtl/gxp_index_hash.sv
`timescale 1ns/1ps
module gxp_index_hash #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int HIST_BITS = 8
) (
    input  logic [PC_W-1:0]      pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [HIST_BITS-1:0] idx
);

    logic                 unused_pc_parity;
    logic [HIST_BITS-1:0] pc_slice;

    assign pc_slice         = pc[PC_LSB +: HIST_BITS];
    assign idx              = pc_slice ^ hist;
    assign unused_pc_parity = ^pc;

endmodule

// File: rtl/gxp_pattern_table.sv
`timescale 1ns/1ps
module gxp_pattern_table
    import gxp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  dir_e             wr_dir
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ctr_q[i] <= CTR_RESET;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ctr_q[i] <= ctr_step(ctr_q[i], wr_dir);
            end
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        AST_CTR_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ctr_q[g])); // R4

        AST_CTR_INC: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && wr_dir == DIR_TAKEN && ctr_q[g] != CTR_MAX)
            |=> ctr_q[g] == ctr_t'($past(ctr_q[g]) + 2'd1)); // R5

        AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && wr_dir == DIR_NOT_TAKEN && ctr_q[g] != CTR_MIN)
            |=> ctr_q[g] == ctr_t'($past(ctr_q[g]) - 2'd1)); // R5

        AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && wr_dir == DIR_TAKEN && ctr_q[g] == CTR_MAX)
            |=> ctr_q[g] == CTR_MAX); // R6

        AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && wr_dir == DIR_NOT_TAKEN && ctr_q[g] == CTR_MIN)
            |=> ctr_q[g] == CTR_MIN); // R6
    end

endmodule

// File: rtl/ghist_xor_predictor.sv
`timescale 1ns/1ps
module ghist_xor_predictor
    import gxp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int HIST_BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_vld,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            resolve_vld,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken,
    output logic            pred_taken
);

    localparam int IDX_W = HIST_BITS;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        dir_e             dir;
    } train_req_t;

    logic [HIST_BITS-1:0] hist;
    logic [IDX_W-1:0]     fetch_idx;
    logic [IDX_W-1:0]     resolve_idx;
    ctr_t                 fetch_ctr;
    train_req_t           train;

    gxp_history #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (resolve_vld),
        .shift_in (resolve_taken),
        .hist     (hist)
    );

    gxp_index_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_BITS(HIST_BITS)) u_fetch_hash (
        .pc   (fetch_pc),
        .hist (hist),
        .idx  (fetch_idx)
    );

    gxp_index_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_BITS(HIST_BITS)) u_resolve_hash (
        .pc   (resolve_pc),
        .hist (hist),
        .idx  (resolve_idx)
    );

    always_comb begin
        train.en  = resolve_vld;
        train.idx = resolve_idx;
        train.dir = dir_e'(resolve_taken);
    end

    gxp_pattern_table #(.IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (fetch_idx),
        .rd_ctr (fetch_ctr),
        .wr_en  (train.en),
        .wr_idx (train.idx),
        .wr_dir (train.dir)
    );

    assign pred_taken = fetch_vld && (ctr_dir(fetch_ctr) == DIR_TAKEN);

    AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |-> !pred_taken); // R3

endmodule

// File: tb/ghist_xor_predictor_test.sv
`timescale 1ns/1ps
module ghist_xor_predictor_test;

    localparam int PC_W = 32;
    localparam int PC_LSB = 2;
    localparam int HB = 8;
    localparam int DEPTH = 1 << HB;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fetch_vld = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            resolve_vld = 1'b0;
    logic [PC_W-1:0] resolve_pc = '0;
    logic            resolve_taken = 1'b0;
    logic            pred_taken;

    always #2 clk = ~clk;

    ghist_xor_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_BITS(HB)) uut (
        .clk           (clk),
        .rst           (rst),
        .fetch_vld     (fetch_vld),
        .fetch_pc      (fetch_pc),
        .resolve_vld   (resolve_vld),
        .resolve_pc    (resolve_pc),
        .resolve_taken (resolve_taken),
        .pred_taken    (pred_taken)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t    sb_q[$];
    int       n_checks = 0;
    int       n_fail = 0;
    logic [1:0]    m_ctr [DEPTH];
    logic [HB-1:0] m_hist;
    bit       done = 0;

    function automatic logic [HB-1:0] m_idx(logic [PC_W-1:0] pc);
        return pc[PC_LSB +: HB] ^ m_hist;
    endfunction

    task automatic model_reset();
        m_hist = '0;
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd1;
    endtask

    task automatic check(logic act, logic exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pred_taken=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: drives one cycle, queues the expected prediction, updates the model.
    task automatic step(logic fv, logic [PC_W-1:0] fpc, logic rv,
                        logic [PC_W-1:0] rpc, logic rt, string tag);
        item_t it;
        logic [HB-1:0] ri;
        @(negedge clk);
        fetch_vld     = fv;
        fetch_pc      = fpc;
        resolve_vld   = rv;
        resolve_pc    = rpc;
        resolve_taken = rt;
        it.exp = fv ? m_ctr[m_idx(fpc)][1] : 1'b0;
        it.tag = tag;
        sb_q.push_back(it);
        if (rv) begin
            ri = m_idx(rpc);
            if (rt) m_ctr[ri] = (m_ctr[ri] == 2'd3) ? 2'd3 : m_ctr[ri] + 2'd1;
            else    m_ctr[ri] = (m_ctr[ri] == 2'd0) ? 2'd0 : m_ctr[ri] - 2'd1;
            m_hist = {m_hist[HB-2:0], rt};
        end
    endtask

    task automatic train(logic [PC_W-1:0] pc, logic rt, string tag);
        step(1'b0, '0, 1'b1, pc, rt, tag);
    endtask

    task automatic probe(logic [PC_W-1:0] pc, string tag);
        step(1'b1, pc, 1'b0, '0, 1'b0, tag);
    endtask

    // Monitor: compares the output one time unit after each falling edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(pred_taken, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        logic [PC_W-1:0] pa;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: after reset every entry reads weakly not-taken
        for (int i = 0; i < 16; i++) probe(PC_W'(i * 4 * 17), "R1_reset");

        // R2 / R5: train one address taken with history driven to all ones
        pa = 32'h0000_1A40;
        for (int i = 0; i < 8; i++) train(pa, 1'b1, "R7_fill");
        train(pa, 1'b1, "R5_inc");
        probe(pa, "R2_taken_after_train");
        // R6: push past the upper limit, then one step down stays taken
        for (int i = 0; i < 4; i++) train(pa, 1'b1, "R6_hi");
        step(1'b1, pa, 1'b1, pa, 1'b1, "R6_hi_sat");
        // R3: a taken entry is masked while fetch_vld is low
        step(1'b0, pa, 1'b0, '0, 1'b0, "R3_idle");
        train(pa, 1'b0, "R6_down");
        probe(pa ^ 32'h0000_0004, "R6_after_down");
        for (int i = 0; i < 8; i++) probe(PC_W'(i * 4), "R2_sweep");

        // R6 low limit: history driven to zeros, then repeated not-taken
        for (int i = 0; i < 8; i++) train(32'h0000_0300, 1'b0, "R7_zero");
        for (int i = 0; i < 4; i++) train(32'h0000_0300, 1'b0, "R6_lo");
        train(32'h0000_0300, 1'b1, "R6_lo_up");
        train(32'h0000_0300 ^ 32'h4, 1'b1, "R6_lo_up2");
        probe(32'h0000_0300, "R6_lo_probe");
        probe(32'h0000_0308, "R6_lo_probe2");

        // R4: resolve fields toggle while resolve_vld is low
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b0, PC_W'(i * 52), 1'b1, "R4_ignored");
        for (int i = 0; i < 16; i++) probe(PC_W'(i * 4), "R4_unchanged");

        // R8: fetch and resolve hit the same entry in one cycle
        for (int i = 0; i < 3; i++) train(32'h0000_0080, 1'b1, "R8_prep");
        for (int i = 0; i < 4; i++)
            step(1'b1, 32'h0000_0080, 1'b1, 32'h0000_0080, 1'b1, "R8_same_cycle");
        for (int i = 0; i < 4; i++)
            step(1'b1, 32'h0000_0044, 1'b1, 32'h0000_0044, 1'b0, "R8_same_cycle_nt");

        // R9: bits outside the slice do not move the index
        train(32'h0000_0120, 1'b1, "R9_train");
        train(32'hFFFF_FD23, 1'b1, "R9_train_alias");
        probe(32'h0000_0120, "R9_base");
        probe(32'hABCD_0123, "R9_alias");
        probe(32'h5500_0122, "R9_alias2");

        // R2 / R5 / R7: pseudo-random mixed traffic against the model
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], PC_W'({lf[9:2], 2'b00}) ^ PC_W'({lf[15:12], 12'h0}),
                 lf[1], PC_W'({lf[6:0] ^ lf[14:8], 2'b00}), lf[3] | lf[4],
                 "R5_R7_mixed");
        end

        @(negedge clk);
        fetch_vld = 1'b0;
        resolve_vld = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: queue left=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule